// File: doc/BRIEF.md
# Load-Use Stall and Bubble Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It compares the destination register of the instruction now in execute with the two source register fields of the instruction held in the fetch/decode register. A hazard exists when the execute-stage instruction is a memory read that targets one of those sources. On a hazard it freezes the program counter and the fetch/decode register for one cycle and turns the next decode/execute entry into a no-operation. It does this by clearing that entry's control fields and leaves the data fields alone. After that single cycle the loaded value reaches execute through the writeback forwarding path.

The block also takes a branch-flush request. A flush squashes the younger instruction in the fetch/decode register and zeroes the control fields of the decode/execute entry being written. It also lets the program counter load the redirect address. A flush always overrides a stall. Register zero is treated as hard-wired when the `ZERO_IS_CONST` option is set, so a load into it never stalls. With the `SINGLE_HOLD` option a granted stall can never be followed directly by another one. This guards the one-cycle rule even if the hazard inputs stay asserted.

Top module: `lu_stall_ctl`

## Requirements
- R1: A stall is granted when `dx_mem_rd` is 1, `dx_rd` is nonzero, and `dx_rd` equals `fd_rs` or `fd_rt`, provided no stall was granted in the previous cycle and `flush` is 0.
- R2: When `dx_mem_rd` is 0, or `dx_rd` matches neither source field, no stall is granted: `pc_we`=1, `fd_we`=1, `dx_zero`=0.
- R3: A memory read whose destination is register 0 never causes a stall.
- R4: During a granted stall, `pc_we`=0 and `fd_we`=0.
- R5: `ctrl_out` equals all zeros whenever `dx_zero`=1, and equals `ctrl_in` otherwise. `dx_zero`=1 exactly when a stall is granted or `flush`=1.
- R6: In the cycle right after a granted stall, no stall is granted, whatever the inputs.
- R7: When `flush`=1: `fd_clr`=1, `dx_zero`=1 and `fd_we`=1. When `flush`=0: `fd_clr`=0.
- R8: When `flush`=1 and a hazard is present in the same cycle, the flush wins: `pc_we`=1 and no stall is recorded for the one-cycle rule.
- R9: After reset, with idle inputs, `pc_we`=1, `fd_we`=1, `dx_zero`=0, `fd_clr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dx_mem_rd | input | 1 | Execute-stage instruction reads memory |
| dx_rd | input | RW | Execute-stage destination register |
| fd_rs | input | RW | First source register of the decoding instruction |
| fd_rt | input | RW | Second source register of the decoding instruction |
| flush | input | 1 | Branch redirect; squash younger instructions |
| ctrl_in | input | CW | Control fields produced by the decoder |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| dx_zero | output | 1 | Zero the control fields entering decode/execute |
| fd_clr | output | 1 | Clear the fetch/decode register |
| ctrl_out | output | CW | Control fields to write into decode/execute |

## Verification
The bench uses a 3-bit register field. It walks every combination of memory-read flag, destination, both sources and flush in sequence, so each vector also sees the stall state left by the one before it. This separates matches on the first source from matches on the second. It also separates a zero destination from a nonzero one, a fresh hazard from one that repeats right after a stall, and a flush alone from a flush that collides with a hazard. Two short directed sequences follow a load through the pipeline. A dependent successor must produce exactly one bubble and an independent successor none.

// File: rtl/lu_pkg.sv
package lu_pkg;
   // Front-end action chosen each cycle
   typedef enum logic [1:0] {
      LU_RUN    = 2'd0,
      LU_HOLD   = 2'd1,
      LU_SQUASH = 2'd2
   } lu_act_e;

   function automatic lu_act_e lu_pick(input logic flush, input logic hold);
      if (flush)     return LU_SQUASH;
      else if (hold) return LU_HOLD;
      else           return LU_RUN;
   endfunction
endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
   parameter int RW            = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [RW-1:0] dst,
   input  logic [RW-1:0] src,
   output logic          hit
);
   if (RW < 1) begin : g_bad_rw
      $error("lu_src_cmp: RW must be at least 1");
   end

   logic same;
   assign same = (dst == src);

   if (ZERO_IS_CONST) begin : g_zero_exempt
      assign hit = same && (dst != '0);
   end else begin : g_plain
      assign hit = same;
   end
endmodule

// File: rtl/lu_hold_gate.sv
module lu_hold_gate #(
   parameter bit SINGLE_HOLD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic flush,
   output logic grant
);
   logic held_q;

   if (SINGLE_HOLD) begin : g_single
      assign grant = req && !flush && !held_q;
   end else begin : g_free
      assign grant = req && !flush;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= grant;
   end

   if (SINGLE_HOLD) begin : g_chk
      assert_one_cycle_hold_R6: assert property (
         @(posedge clk) disable iff (!rst_n) grant |=> !grant)
         else $error("stall granted twice in a row");
   end
endmodule

// File: rtl/lu_ctrl_zero.sv
module lu_ctrl_zero #(
   parameter int CW = 8
) (
   input  logic          zero,
   input  logic [CW-1:0] ctrl_in,
   output logic [CW-1:0] ctrl_out
);
   if (CW < 1) begin : g_bad_cw
      $error("lu_ctrl_zero: CW must be at least 1");
   end

   for (genvar i = 0; i < CW; i++) begin : g_bit
      assign ctrl_out[i] = ctrl_in[i] & ~zero;
   end
endmodule

// File: rtl/lu_stall_ctl.sv
module lu_stall_ctl #(
   parameter int RW            = 5,
   parameter int CW            = 8,
   parameter bit ZERO_IS_CONST = 1'b1,
   parameter bit SINGLE_HOLD   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dx_mem_rd,
   input  logic [RW-1:0] dx_rd,
   input  logic [RW-1:0] fd_rs,
   input  logic [RW-1:0] fd_rt,
   input  logic          flush,
   input  logic [CW-1:0] ctrl_in,
   output logic          pc_we,
   output logic          fd_we,
   output logic          dx_zero,
   output logic          fd_clr,
   output logic [CW-1:0] ctrl_out
);
   import lu_pkg::*;

   localparam int NSRC = 2;

   logic [RW-1:0]   src [NSRC];
   logic [NSRC-1:0] hit;
   logic            hazard;
   logic            grant;
   lu_act_e         act;

   assign src[0] = fd_rs;
   assign src[1] = fd_rt;

   for (genvar s = 0; s < NSRC; s++) begin : g_cmp
      lu_src_cmp #(.RW(RW), .ZERO_IS_CONST(ZERO_IS_CONST)) u_cmp (
         .dst (dx_rd),
         .src (src[s]),
         .hit (hit[s])
      );
   end

   assign hazard = dx_mem_rd && (|hit);

   lu_hold_gate #(.SINGLE_HOLD(SINGLE_HOLD)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (hazard),
      .flush (flush),
      .grant (grant)
   );

   assign act = lu_pick(flush, grant);

   always_comb begin
      pc_we   = 1'b1;
      fd_we   = 1'b1;
      dx_zero = 1'b0;
      fd_clr  = 1'b0;
      unique case (act)
         LU_HOLD: begin
            pc_we   = 1'b0;
            fd_we   = 1'b0;
            dx_zero = 1'b1;
         end
         LU_SQUASH: begin
            dx_zero = 1'b1;
            fd_clr  = 1'b1;
         end
         default: ;
      endcase
   end

   lu_ctrl_zero #(.CW(CW)) u_zero (
      .zero     (dx_zero),
      .ctrl_in  (ctrl_in),
      .ctrl_out (ctrl_out)
   );

   assert_grant_needs_load_R1: assert property (
      @(posedge clk) disable iff (!rst_n) grant |-> (dx_mem_rd && (dx_rd == fd_rs || dx_rd == fd_rt)))
      else $error("stall without a matching load");

   assert_front_frozen_R4: assert property (
      @(posedge clk) disable iff (!rst_n) grant |-> (!pc_we && !fd_we))
      else $error("front end moved during stall");

   assert_bubble_zeroed_R5: assert property (
      @(posedge clk) disable iff (!rst_n) dx_zero |-> (ctrl_out == '0))
      else $error("bubble carries control bits");

   assert_flush_squash_R7: assert property (
      @(posedge clk) disable iff (!rst_n) flush |-> (fd_clr && dx_zero && fd_we))
      else $error("flush did not squash");

   assert_flush_wins_R8: assert property (
      @(posedge clk) disable iff (!rst_n) flush |-> (pc_we && !grant))
      else $error("stall overrode flush");

   if (ZERO_IS_CONST) begin : g_zchk
      assert_zero_dest_quiet_R3: assert property (
         @(posedge clk) disable iff (!rst_n) (dx_rd == '0) |-> !grant)
         else $error("stall on register zero");
   end
endmodule

// File: tb/lu_stall_ctl_test.sv
`timescale 1ns/100ps
module lu_stall_ctl_test;
   localparam int RW = 3;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dx_mem_rd = 1'b0;
   logic [RW-1:0] dx_rd = '0, fd_rs = '0, fd_rt = '0;
   logic          flush = 1'b0;
   logic [CW-1:0] ctrl_in = '0;
   logic          pc_we, fd_we, dx_zero, fd_clr;
   logic [CW-1:0] ctrl_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   lu_stall_ctl #(.RW(RW), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .dx_mem_rd(dx_mem_rd), .dx_rd(dx_rd),
      .fd_rs(fd_rs), .fd_rt(fd_rt), .flush(flush), .ctrl_in(ctrl_in),
      .pc_we(pc_we), .fd_we(fd_we), .dx_zero(dx_zero), .fd_clr(fd_clr),
      .ctrl_out(ctrl_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      bit prev;
      int bubbles;
      prev = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state with idle inputs
      chk("R9 pc_we", pc_we, 1);
      chk("R9 fd_we", fd_we, 1);
      chk("R9 dx_zero", dx_zero, 0);
      chk("R9 fd_clr", fd_clr, 0);

      // Exhaustive sweep; stall history carried from vector to vector
      for (int v = 0; v < 2048; v++) begin
         bit mr, fl, haz, stl, dz;
         int rd, rs, rt, ci;
         string tg;
         @(negedge clk);
         mr = v[10]; rd = (v >> 7) & 7; rs = (v >> 4) & 7; rt = (v >> 1) & 7; fl = v[0];
         ci = (v ^ (v >> 4)) & 15;
         dx_mem_rd = mr; dx_rd = rd[RW-1:0]; fd_rs = rs[RW-1:0]; fd_rt = rt[RW-1:0];
         flush = fl; ctrl_in = ci[CW-1:0];
         haz = mr && rd != 0 && (rd == rs || rd == rt);
         stl = haz && !prev && !fl;
         dz  = stl || fl;
         if (fl && haz)                               tg = "R8";
         else if (fl)                                 tg = "R7";
         else if (mr && rd == 0 && (rs == 0 || rt == 0)) tg = "R3";
         else if (haz && prev)                        tg = "R6";
         else if (haz)                                tg = "R1/R4";
         else                                         tg = "R2";
         #1;
         chk({tg, " pc_we"}, pc_we, !stl);
         chk({tg, " fd_we"}, fd_we, !stl);
         chk({tg, " dx_zero"}, dx_zero, dz);
         chk("R7 fd_clr", fd_clr, fl);
         chk("R5 ctrl_out", ctrl_out, dz ? 0 : ci);
         @(posedge clk);
         prev = stl;
      end

      // Directed: load r2 then dependent use of r2 -> exactly one bubble (R1)
      @(negedge clk);
      flush = 0; dx_mem_rd = 0; dx_rd = 0; fd_rs = 0; fd_rt = 0; ctrl_in = 4'hF;
      @(negedge clk);
      bubbles = 0;
      dx_mem_rd = 1; dx_rd = 3'd2; fd_rs = 3'd2; fd_rt = 3'd5;
      #1; bubbles += dx_zero;
      @(negedge clk);
      // bubble now sits in execute; dependent instruction re-decoded
      dx_mem_rd = 0; dx_rd = 3'd0;
      #1; bubbles += dx_zero;
      @(negedge clk);
      // dependent instruction advanced into execute
      dx_mem_rd = 0; dx_rd = 3'd4; fd_rs = 3'd6; fd_rt = 3'd1;
      #1; bubbles += dx_zero;
      chk("R1 dependent bubbles", bubbles, 1);

      // Directed: load r2 then independent instruction -> no bubble (R2)
      @(negedge clk);
      bubbles = 0;
      dx_mem_rd = 1; dx_rd = 3'd2; fd_rs = 3'd3; fd_rt = 3'd4;
      #1; bubbles += dx_zero;
      @(negedge clk);
      dx_mem_rd = 0; dx_rd = 3'd7; fd_rs = 3'd1; fd_rt = 3'd1;
      #1; bubbles += dx_zero;
      chk("R2 independent bubbles", bubbles, 0);

      // Directed: second-source match, ctrl passes after hold (R1, R5, R6)
      @(negedge clk);
      dx_mem_rd = 1; dx_rd = 3'd6; fd_rs = 3'd1; fd_rt = 3'd6; ctrl_in = 4'h9;
      #1;
      chk("R1 rt match dx_zero", dx_zero, 1);
      chk("R5 bubble ctrl", ctrl_out, 0);
      @(negedge clk);
      #1;
      chk("R6 held inputs no restall", pc_we, 1);
      chk("R5 ctrl passes", ctrl_out, 9);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule